// File: doc/BRIEF.md
# Two-Queue Conversion Command Arbiter

This block shares one conversion engine between two command queues. Each queue is started by a trigger pulse and walks through its own command list, which sits in an external table. Queue 1 always has priority. Queue 2 runs whenever queue 1 is idle or paused. A queue 2 trigger that arrives while queue 1 is running is held as a pending request and served once queue 1 stops. Each queue reports its state and keeps three sticky flags: done, paused and trigger overrun. Software clears these flags by writing one to them.

The block drives the table address `cmd_addr_o` and reads back two command bits combinationally: an end-of-queue marker and a pause marker. A command with the end marker is not converted. It completes the queue. A command with the pause marker is converted, and then the queue stops until its next trigger.

Requests to the engine flow over a valid/ready channel. Once `conv_valid_o` is raised, `conv_idx_o` stays fixed and the request is held until the engine asserts `conv_ready_i`. The engine signals the end of a conversion with a single `conv_done_i` pulse. Only one request is outstanding at a time, so back-pressure from the engine simply stalls the arbiter. Triggers, flag clears and states are plain control pins.

Top module: `conv_queue_arb`

## Requirements
- R1: When both queues are in the active state and the engine is free, the next request issued is a queue 1 command (an index below the queue 2 base).
- R2: A queue 2 trigger while queue 1 is active puts queue 2 into the triggered state (code 3). Queue 2 becomes active only once queue 1 has left the active state, so all of queue 1's remaining commands are converted before queue 2's. Queue 1 never shows code 3.
- R3: A further queue 2 trigger while queue 2 is pending sets the queue 2 overrun flag (bit 5). Queue 1's command sequence and state are not changed by it, whether or not either queue uses a pause command.
- R4: A trigger on a queue already in the active state sets that queue's overrun flag (bit 2 for queue 1, bit 5 for queue 2) and has no other effect.
- R5: A command whose pause bit is set is converted. The queue then enters the paused state (code 2) and its pause flag is set (bit 1 for queue 1, bit 4 for queue 2). The queue's next trigger resumes it at the following command.
- R6: A command whose end bit is set is not sent to the engine. The queue returns to idle (code 0) and its done flag is set (bit 0 for queue 1, bit 3 for queue 2). A trigger from idle starts queue 1 at index 0 and queue 2 at index `Q2_BASE`.
- R7: While queue 1 is idle or paused, queue 2 uses the engine. A queue 1 trigger during a queue 2 conversion lets that conversion finish, then queue 1 runs, then queue 2 resumes at its next command.
- R8: Writing 1 to a bit of `flag_clr_i` clears that flag, and writing 0 leaves it alone. A flag set in the same cycle as its clear stays set.
- R9: `conv_valid_o` with `conv_idx_o` stays stable until `conv_ready_i`. No new request is raised until `conv_done_i` has answered the previous one.
- R10: After reset both states are idle (code 0), all flags are 0 and no request is raised. State codes: 0 idle, 1 active, 2 paused, 3 triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig1_i | input | 1 | Queue 1 trigger pulse |
| trig2_i | input | 1 | Queue 2 trigger pulse |
| flag_clr_i | input | 6 | Write-one-to-clear strobes, same layout as `flags_o` |
| cmd_addr_o | output | IDX_W | Command table address being examined |
| cmd_eoq_i | input | 1 | End marker of the command at `cmd_addr_o` |
| cmd_pause_i | input | 1 | Pause marker of the command at `cmd_addr_o` |
| conv_valid_o | output | 1 | Conversion request valid |
| conv_ready_i | input | 1 | Engine accepts the request |
| conv_idx_o | output | IDX_W | Command index of the request |
| conv_done_i | input | 1 | Engine finished the accepted conversion |
| q1_state_o | output | 2 | Queue 1 state code |
| q2_state_o | output | 2 | Queue 2 state code |
| flags_o | output | 6 | {ovr2, pause2, done2, ovr1, pause1, done1} |

## Verification
The assertions take for granted that the engine answers only a request it has accepted, with exactly one `conv_done_i` pulse. They also assume each trigger is a single-cycle pulse and that every command list ends in an end marker within the table. The bench stays within these limits. Its engine model raises done only after its own accepted handshake, with a fixed latency. Its command table always places end markers at indices 3 and 10, and it drives triggers and clears for exactly one cycle between falling edges. Ready toggles every cycle, so both the stalled and the accepted paths of the request channel occur.

// File: rtl/cqa_pkg.sv
package cqa_pkg;
  typedef enum logic [1:0] {
    QS_IDLE   = 2'd0,
    QS_ACTIVE = 2'd1,
    QS_PAUSED = 2'd2,
    QS_TRIG   = 2'd3
  } qstate_t;

  typedef enum logic [1:0] {
    E_PICK = 2'd0,
    E_REQ  = 2'd1,
    E_WAIT = 2'd2
  } eng_t;

  localparam int NUM_Q  = 2;
  localparam int FLAG_W = 3; // {ovr, pause, done} per queue
endpackage

// File: rtl/cqa_queue_ctl.sv
module cqa_queue_ctl
  import cqa_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int BASE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              hold_i,
  input  logic              eoq_hit_i,
  input  logic              adv_i,
  input  logic              adv_pause_i,
  input  logic [FLAG_W-1:0] clr_i,
  output qstate_t           state_o,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(BASE);

  qstate_t           st_q, st_n;
  logic [IDX_W-1:0]  ptr_q, ptr_n;
  logic [FLAG_W-1:0] flg_q, set_v;

  always_comb begin
    st_n  = st_q;
    ptr_n = ptr_q;
    set_v = '0;
    if (eoq_hit_i) begin
      st_n     = QS_IDLE;
      set_v[0] = 1'b1;
    end else if (adv_i) begin
      ptr_n = ptr_q + 1'b1;
      if (adv_pause_i) begin
        st_n     = QS_PAUSED;
        set_v[1] = 1'b1;
      end
    end
    if (trig_i) begin
      unique case (st_q)
        QS_IDLE: begin
          ptr_n = BASE_IDX;
          st_n  = hold_i ? QS_TRIG : QS_ACTIVE;
        end
        QS_PAUSED: st_n = hold_i ? QS_TRIG : QS_ACTIVE;
        default:   set_v[2] = 1'b1;
      endcase
    end
    if (st_q == QS_TRIG && !hold_i) st_n = QS_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= QS_IDLE;
      ptr_q <= BASE_IDX;
      flg_q <= '0;
    end else begin
      st_q  <= st_n;
      ptr_q <= ptr_n;
      flg_q <= (flg_q & ~clr_i) | set_v;
    end
  end

  assign state_o = st_q;
  assign ptr_o   = ptr_q;
  assign flags_o = flg_q;

  AST_OVR_ON_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && st_q == QS_ACTIVE) |=> flags_o[2]); // R4
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && st_q == QS_TRIG && clr_i[2]) |=> flags_o[2]); // R8
  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == QS_TRIG && hold_i) |=> state_o == QS_TRIG); // R2
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoq_hit_i && !trig_i) |=> (state_o == QS_IDLE && flags_o[0])); // R6
  AST_PAUSE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && adv_pause_i && !eoq_hit_i && !trig_i) |=> (state_o == QS_PAUSED && flags_o[1])); // R5
endmodule

// File: rtl/cqa_engine_seq.sv
module cqa_engine_seq
  import cqa_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] q_active_i,
  input  logic [IDX_W-1:0] ptr0_i,
  input  logic [IDX_W-1:0] ptr1_i,
  output logic [IDX_W-1:0] cmd_addr_o,
  input  logic             cmd_eoq_i,
  input  logic             cmd_pause_i,
  output logic             conv_valid_o,
  input  logic             conv_ready_i,
  output logic [IDX_W-1:0] conv_idx_o,
  input  logic             conv_done_i,
  output logic [NUM_Q-1:0] eoq_hit_o,
  output logic [NUM_Q-1:0] adv_o,
  output logic             adv_pause_o
);
  eng_t             st_q;
  logic             sel_q, owner_q, pause_q, any_act;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    any_act    = |q_active_i;
    sel_q      = !q_active_i[0];
    cmd_addr_o = sel_q ? ptr1_i : ptr0_i;
    eoq_hit_o  = '0;
    adv_o      = '0;
    if (st_q == E_PICK && any_act && cmd_eoq_i) eoq_hit_o[sel_q] = 1'b1;
    if (st_q == E_WAIT && conv_done_i)          adv_o[owner_q]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= E_PICK;
      owner_q <= 1'b0;
      pause_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      unique case (st_q)
        E_PICK: if (any_act && !cmd_eoq_i) begin
          owner_q <= sel_q;
          idx_q   <= cmd_addr_o;
          pause_q <= cmd_pause_i;
          st_q    <= E_REQ;
        end
        E_REQ:  if (conv_ready_i) st_q <= E_WAIT;
        E_WAIT: if (conv_done_i)  st_q <= E_PICK;
        default: st_q <= E_PICK;
      endcase
    end
  end

  assign conv_valid_o = (st_q == E_REQ);
  assign conv_idx_o   = idx_q;
  assign adv_pause_o  = pause_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid_o && !conv_ready_i) |=> (conv_valid_o && $stable(conv_idx_o))); // R9
  AST_DONE_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_i |-> (st_q == E_WAIT && !conv_valid_o)); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eoq_hit_o, adv_o})); // R6
endmodule

// File: rtl/conv_queue_arb.sv
module conv_queue_arb
  import cqa_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int Q2_BASE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig1_i,
  input  logic             trig2_i,
  input  logic [5:0]       flag_clr_i,
  output logic [IDX_W-1:0] cmd_addr_o,
  input  logic             cmd_eoq_i,
  input  logic             cmd_pause_i,
  output logic             conv_valid_o,
  input  logic             conv_ready_i,
  output logic [IDX_W-1:0] conv_idx_o,
  input  logic             conv_done_i,
  output logic [1:0]       q1_state_o,
  output logic [1:0]       q2_state_o,
  output logic [5:0]       flags_o
);
  localparam logic [IDX_W-1:0] Q2_IDX = IDX_W'(Q2_BASE);

  qstate_t           st   [NUM_Q];
  logic [IDX_W-1:0]  ptr  [NUM_Q];
  logic [FLAG_W-1:0] flg  [NUM_Q];
  logic [NUM_Q-1:0]  trig, act, eoq_hit, adv;
  logic              adv_pause;

  assign trig = {trig2_i, trig1_i};

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic hold;
    if (g == 0) begin : g_hi
      assign hold = 1'b0;
    end else begin : g_lo
      assign hold = (st[0] == QS_ACTIVE);
    end
    cqa_queue_ctl #(.IDX_W(IDX_W), .BASE(g == 0 ? 0 : Q2_BASE)) ctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig[g]),
      .hold_i      (hold),
      .eoq_hit_i   (eoq_hit[g]),
      .adv_i       (adv[g]),
      .adv_pause_i (adv_pause),
      .clr_i       (flag_clr_i[g*FLAG_W +: FLAG_W]),
      .state_o     (st[g]),
      .ptr_o       (ptr[g]),
      .flags_o     (flg[g])
    );
    assign act[g] = (st[g] == QS_ACTIVE);
  end

  cqa_engine_seq #(.IDX_W(IDX_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_active_i   (act),
    .ptr0_i       (ptr[0]),
    .ptr1_i       (ptr[1]),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_eoq_i    (cmd_eoq_i),
    .cmd_pause_i  (cmd_pause_i),
    .conv_valid_o (conv_valid_o),
    .conv_ready_i (conv_ready_i),
    .conv_idx_o   (conv_idx_o),
    .conv_done_i  (conv_done_i),
    .eoq_hit_o    (eoq_hit),
    .adv_o        (adv),
    .adv_pause_o  (adv_pause)
  );

  assign q1_state_o = st[0];
  assign q2_state_o = st[1];
  assign flags_o    = {flg[1], flg[0]};

  AST_Q1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv_valid_o) && $past(q1_state_o == 2'd1)) |-> (conv_idx_o < Q2_IDX)); // R1
  AST_Q1_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    q1_state_o != 2'd3); // R2
  AST_Q2_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_state_o == 2'd1 && q2_state_o != 2'd1) |=> q2_state_o != 2'd1); // R2
endmodule

// File: tb/conv_queue_arb_tb_top.sv
module conv_queue_arb_tb_top;
  localparam int IDX_W = 4;
  localparam int Q2B   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig1 = 1'b0, trig2 = 1'b0;
  logic [5:0] clr = '0;
  logic [IDX_W-1:0] cmd_addr, conv_idx;
  logic cmd_eoq, cmd_pause, conv_valid, conv_ready, conv_done;
  logic [1:0] q1s, q2s;
  logic [5:0] flags;

  logic tbl_eoq [16];
  logic tbl_pause [16];
  int   log_q [$];
  int   exp_q [$];
  int   total = 0, bad = 0;

  always #2 clk = ~clk;

  conv_queue_arb #(.IDX_W(IDX_W), .Q2_BASE(Q2B)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig1_i(trig1), .trig2_i(trig2), .flag_clr_i(clr),
    .cmd_addr_o(cmd_addr), .cmd_eoq_i(cmd_eoq), .cmd_pause_i(cmd_pause),
    .conv_valid_o(conv_valid), .conv_ready_i(conv_ready), .conv_idx_o(conv_idx),
    .conv_done_i(conv_done), .q1_state_o(q1s), .q2_state_o(q2s), .flags_o(flags));

  assign cmd_eoq   = tbl_eoq[cmd_addr];
  assign cmd_pause = tbl_pause[cmd_addr];

  // engine model: ready toggles, done after fixed latency
  logic rdy_t, busy_m;
  int   lat;
  assign conv_ready = rdy_t;
  always @(posedge clk) begin
    if (!rst_n) begin
      rdy_t <= 1'b0; busy_m <= 1'b0; lat <= 0; conv_done <= 1'b0;
    end else begin
      rdy_t     <= ~rdy_t;
      conv_done <= 1'b0;
      if (conv_valid && conv_ready) begin
        busy_m <= 1'b1; lat <= 3;
        log_q.push_back(int'(conv_idx));
      end else if (busy_m) begin
        if (lat == 0) begin conv_done <= 1'b1; busy_m <= 1'b0; end
        else lat <= lat - 1;
      end
    end
  end

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic chk_log(string req);
    int ok = (log_q.size() == exp_q.size());
    if (ok != 0) for (int i = 0; i < exp_q.size(); i++) if (log_q[i] != exp_q[i]) ok = 0;
    total++;
    if (ok == 0) begin
      bad++;
      $display("FAIL %s order actual_len=%0d expected_len=%0d actual_first=%0d expected_first=%0d",
               req, log_q.size(), exp_q.size(),
               (log_q.size() > 0) ? log_q[0] : -1, (exp_q.size() > 0) ? exp_q[0] : -1);
    end
  endtask

  task automatic pulse(logic t1, logic t2, logic [5:0] c);
    @(negedge clk); trig1 = t1; trig2 = t2; clr = c;
    @(negedge clk); trig1 = 1'b0; trig2 = 1'b0; clr = '0;
  endtask

  task automatic settle();
    int quiet = 0;
    for (int i = 0; i < 600 && quiet < 3; i++) begin
      @(negedge clk);
      if (!conv_valid && !busy_m && !conv_done && q1s != 2'd1 && q1s != 2'd3 &&
          q2s != 2'd1 && q2s != 2'd3) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic fresh(logic p2);
    for (int i = 0; i < 16; i++) begin tbl_eoq[i] = 1'b0; tbl_pause[i] = 1'b0; end
    tbl_eoq[3] = 1'b1; tbl_eoq[10] = 1'b1; tbl_pause[8] = p2;
    pulse(1'b0, 1'b0, 6'h3f);
    log_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fresh(1'b0);
    repeat (3) @(negedge clk);
    chk("R10 q1 state", int'(q1s), 0);
    chk("R10 q2 state", int'(q2s), 0);
    chk("R10 flags", int'(flags), 0);
    chk("R10 valid", int'(conv_valid), 0);
    rst_n = 1'b1;

    // R6 single queue 1 run
    fresh(1'b0);
    pulse(1'b1, 1'b0, 6'h00);
    chk("R6 q1 active", int'(q1s), 1);
    settle();
    exp_q = '{0, 1, 2};
    chk_log("R6 q1 run");
    chk("R6 done1", int'(flags), 6'h01);
    pulse(1'b0, 1'b0, 6'h01);
    chk("R8 clear done1", int'(flags), 0);

    // R2 R3 R5 sweep: number of q2 triggers during q1, q2 pause on/off
    for (int p = 0; p < 2; p++) begin
      for (int k = 1; k <= 3; k++) begin
        fresh(p[0]);
        pulse(1'b1, 1'b0, 6'h00);
        @(negedge clk);
        for (int i = 0; i < k; i++) begin
          pulse(1'b0, 1'b1, 6'h00);
          if (i == 0) chk("R2 q2 pending", int'(q2s), 3);
          @(negedge clk);
        end
        chk("R3 q1 undisturbed", int'(q1s), 1);
        settle();
        exp_q = '{0, 1, 2, 8};
        if (p == 0) exp_q.push_back(9);
        chk_log("R2 R3 order");
        chk("R3 R5 flags", int'(flags),
            1 + ((p == 1) ? 16 : 8) + ((k > 1) ? 32 : 0));
        chk("R5 q2 state", int'(q2s), (p == 1) ? 2 : 0);
        if (p == 1) begin
          pulse(1'b0, 1'b1, 6'h00);
          settle();
          exp_q.push_back(9);
          chk_log("R5 resume");
          chk("R5 done2", int'(flags[3]), 1);
        end
      end
    end

    // R5 R7 queue 1 pause, queue 2 runs meanwhile
    fresh(1'b0);
    tbl_pause[1] = 1'b1;
    pulse(1'b1, 1'b0, 6'h00);
    settle();
    exp_q = '{0, 1};
    chk_log("R5 q1 pause");
    chk("R5 q1 paused", int'(q1s), 2);
    chk("R5 pause1", int'(flags), 6'h02);
    pulse(1'b0, 1'b1, 6'h00);
    settle();
    exp_q = '{0, 1, 8, 9};
    chk_log("R7 q2 while q1 paused");
    pulse(1'b1, 1'b0, 6'h00);
    settle();
    exp_q = '{0, 1, 8, 9, 2};
    chk_log("R5 q1 resume");
    chk("R5 flags", int'(flags), 6'h0b);

    // R7 R1 R4 queue 1 trigger during a queue 2 conversion
    fresh(1'b0);
    pulse(1'b0, 1'b1, 6'h00);
    for (int i = 0; i < 50 && !conv_valid; i++) @(negedge clk);
    pulse(1'b1, 1'b0, 6'h00);
    pulse(1'b0, 1'b1, 6'h00);
    settle();
    exp_q = '{8, 0, 1, 2, 9};
    chk_log("R7 R1 preempt order");
    chk("R4 ovr2 flags", int'(flags), 6'h29);

    // R4 R8 retrigger queue 1 while active, clear in same cycle
    fresh(1'b0);
    pulse(1'b1, 1'b0, 6'h00);
    pulse(1'b1, 1'b0, 6'h04);
    chk("R8 set beats clear", int'(flags[2]), 1);
    chk("R4 q1 still active", int'(q1s), 1);
    settle();
    exp_q = '{0, 1, 2};
    chk_log("R4 retrigger ignored");
    chk("R4 flags", int'(flags), 6'h05);
    pulse(1'b0, 1'b0, 6'h01);
    chk("R8 partial clear", int'(flags), 6'h04);
    pulse(1'b0, 1'b0, 6'h04);
    chk("R8 clear ovr1", int'(flags), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule